// File: doc/BRIEF.md
# Video Capture Frame Sequencer

This block controls when one video capture channel stores pixels and when that capture counts as finished. It receives frame and field boundary strobes, a field identifier, and the horizontal and vertical position inside the current field. Its outputs are a capture-active qualifier for the pixel path, sticky done flags for the host, and a completion interrupt.

The host selects what is captured: field 1 alone, field 2 alone, or a whole frame made of both fields. It also selects what happens after a capture completes. The capture can restart on its own. It can run once more and then stop if the host has not acknowledged the previous result. Or it can stop after one capture until the host acknowledges it. The channel arms on the frame boundary that follows the enable. Capture then begins on the first selected field. A capture ends on the pixel whose coordinates equal the programmed stop point.

Top module: `vcap_frame_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cap_active`, `f1_done`, `f2_done`, `frm_done`, `cmp_done` and `irq` are all 0.
- R2: With `cap_en` high, the channel arms on a `frame_start` strobe. `cap_active` rises one cycle after the first `field_start` of a selected field seen in that cycle or later. `sel_mode` selects 0 = field 1 (`field_id`=0), 1 = field 2 (`field_id`=1), 2 or 3 = frame (starts at `field_id`=0).
- R3: A capture completes in the cycle where `cap_active` is high, `h_pos` equals `stop_size[POS_W-1:0]` and `v_pos` equals `stop_size[2*POS_W-1:POS_W]`. In frame mode this must also happen inside field 2. One cycle later the flag of the selected mode (`f1_done`, `f2_done` or `frm_done`) is 1 and `cap_active` is 0.
- R4: Every completion also sets `cmp_done` one cycle later. `irq` is high exactly when `cmp_done` and `irq_en` are both high.
- R5: With `run_mode`=0 (continuous), capture restarts on the next selected field start, with no further frame boundary needed.
- R6: With `run_mode`=1 (non-continuous), the capture after a completion still takes place. At its completion, if the selected flag is still set and not being cleared in that cycle, the channel halts. A halted channel returns to idle once the flag reads 0, and arms again on the next `frame_start`.
- R7: With `run_mode`=2 or 3 (single), the channel halts after every completion and stays halted until the selected flag reads 0. It then arms again on the next `frame_start`.
- R8: `clr_f1`, `clr_f2`, `clr_frm` and `clr_cmp` clear their flag one cycle after a 1. A flag is otherwise held. When a set and a clear of the same flag meet in one cycle, the flag ends up set.
- R9: A `frame_start` while `cap_en` is low puts the channel idle on the next cycle, with `cap_active` 0. No flag changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable, acted on at frame boundaries |
| frame_start | input | 1 | Strobe on the first cycle of a frame |
| field_start | input | 1 | Strobe on the first cycle of a field |
| field_id | input | 1 | Current field: 0 = field 1, 1 = field 2 |
| h_pos | input | POS_W | Horizontal position in the field |
| v_pos | input | POS_W | Vertical position in the field |
| stop_size | input | 2*POS_W | Stop point: low half X, high half Y |
| sel_mode | input | 2 | Capture selection (see R2) |
| run_mode | input | 2 | Continuation policy (see R5 to R7) |
| clr_f1 | input | 1 | Write-one-to-clear for f1_done |
| clr_f2 | input | 1 | Write-one-to-clear for f2_done |
| clr_frm | input | 1 | Write-one-to-clear for frm_done |
| clr_cmp | input | 1 | Write-one-to-clear for cmp_done |
| irq_en | input | 1 | Completion interrupt enable |
| cap_active | output | 1 | High while pixels are being stored |
| f1_done | output | 1 | Sticky field-1 done flag |
| f2_done | output | 1 | Sticky field-2 done flag |
| frm_done | output | 1 | Sticky frame done flag |
| cmp_done | output | 1 | Sticky summary completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer state shows at the ports within one field. Examples are arming on the wrong boundary, missing a halt, or leaving a halt too early. The error appears as a `cap_active` edge in the wrong cycle, or as a capture that appears or vanishes at the next field start. A wrong flag update shows one cycle after the stop pixel or after a clear strobe. The bench models the channel cycle by cycle and compares every output on every clock. It also counts capture starts per scenario against hand-derived totals for each continuation policy.

// File: rtl/vcap_seq_pkg.sv
package vcap_seq_pkg;

    typedef enum logic [1:0] {
        SEL_F1  = 2'd0,
        SEL_F2  = 2'd1,
        SEL_FRM = 2'd2,
        SEL_ALT = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        RUN_CONT   = 2'd0,
        RUN_ACK    = 2'd1,
        RUN_SINGLE = 2'd2,
        RUN_ALT    = 2'd3
    } run_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_HALT  = 2'd3
    } st_e;

    localparam int unsigned NUM_DONE = 3;
    localparam int unsigned IDX_F1   = 0;
    localparam int unsigned IDX_F2   = 1;
    localparam int unsigned IDX_FRM  = 2;

    function automatic logic is_frame(sel_e s);
        return (s == SEL_FRM) || (s == SEL_ALT);
    endfunction

    function automatic logic field_selected(sel_e s, logic fid);
        if (s == SEL_F2) return fid;
        return !fid;
    endfunction

    function automatic logic [NUM_DONE-1:0] done_mask(sel_e s);
        logic [NUM_DONE-1:0] m;
        m = '0;
        case (s)
            SEL_F1:  m[IDX_F1]  = 1'b1;
            SEL_F2:  m[IDX_F2]  = 1'b1;
            default: m[IDX_FRM] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vcap_seq_window.sv
module vcap_seq_window
    import vcap_seq_pkg::*;
#(
    parameter int unsigned POS_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               field_start,
    input  logic               field_id,
    input  logic [POS_W-1:0]   h_pos,
    input  logic [POS_W-1:0]   v_pos,
    input  logic [2*POS_W-1:0] stop_size,
    input  sel_e               sel,
    input  logic               capturing,
    output logic               hit
);
    logic             cur_fld;
    logic             eff_fld;
    logic [POS_W-1:0] x_stop;
    logic [POS_W-1:0] y_stop;

    assign x_stop  = stop_size[POS_W-1:0];
    assign y_stop  = stop_size[2*POS_W-1:POS_W];
    assign eff_fld = field_start ? field_id : cur_fld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_fld <= 1'b0;
        end else if (field_start) begin
            cur_fld <= field_id;
        end
    end

    always_comb begin
        hit = capturing && (h_pos == x_stop) && (v_pos == y_stop)
              && (!is_frame(sel) || eff_fld);
    end
endmodule

// File: rtl/vcap_seq_fsm.sv
module vcap_seq_fsm
    import vcap_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic frame_start,
    input  logic field_start,
    input  logic field_id,
    input  sel_e sel,
    input  run_e run,
    input  logic hit,
    input  logic sel_flag,
    input  logic sel_clr,
    output logic capturing
);
    st_e  st_q, st_d;
    logic begin_ok;

    assign begin_ok  = field_start && field_selected(sel, field_id);
    assign capturing = (st_q == ST_CAPT);

    always_comb begin
        st_d = st_q;
        if (frame_start && !cap_en) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (frame_start && cap_en)
                        st_d = begin_ok ? ST_CAPT : ST_ARMED;
                end
                ST_ARMED: begin
                    if (begin_ok) st_d = ST_CAPT;
                end
                ST_CAPT: begin
                    if (hit) begin
                        case (run)
                            RUN_CONT: st_d = ST_ARMED;
                            RUN_ACK:  st_d = (sel_flag && !sel_clr) ? ST_HALT : ST_ARMED;
                            default:  st_d = ST_HALT;
                        endcase
                    end
                end
                default: begin
                    if (!sel_flag) st_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/vcap_seq_flags.sv
module vcap_seq_flags
    import vcap_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  sel_e                sel,
    input  logic [NUM_DONE-1:0] clr,
    input  logic                clr_cmp,
    input  logic                irq_en,
    output logic [NUM_DONE-1:0] done,
    output logic                cmp_done,
    output logic                irq,
    output logic                sel_flag,
    output logic                sel_clr
);
    logic [NUM_DONE-1:0] mask;
    logic [NUM_DONE-1:0] set_v;

    assign mask  = done_mask(sel);
    assign set_v = hit ? mask : '0;

    for (genvar i = 0; i < NUM_DONE; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) done[i] <= 1'b0;
            else     done[i] <= (done[i] & ~clr[i]) | set_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmp_done <= 1'b0;
        else     cmp_done <= (cmp_done & ~clr_cmp) | hit;
    end

    assign irq      = cmp_done & irq_en;
    assign sel_flag = |(done & mask);
    assign sel_clr  = |(clr & mask);
endmodule

// File: rtl/vcap_frame_seq.sv
module vcap_frame_seq
    import vcap_seq_pkg::*;
#(
    parameter int unsigned POS_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               frame_start,
    input  logic               field_start,
    input  logic               field_id,
    input  logic [POS_W-1:0]   h_pos,
    input  logic [POS_W-1:0]   v_pos,
    input  logic [2*POS_W-1:0] stop_size,
    input  logic [1:0]         sel_mode,
    input  logic [1:0]         run_mode,
    input  logic               clr_f1,
    input  logic               clr_f2,
    input  logic               clr_frm,
    input  logic               clr_cmp,
    input  logic               irq_en,
    output logic               cap_active,
    output logic               f1_done,
    output logic               f2_done,
    output logic               frm_done,
    output logic               cmp_done,
    output logic               irq
);
    sel_e                sel;
    run_e                run;
    logic                hit;
    logic                capturing;
    logic                sel_flag;
    logic                sel_clr;
    logic [NUM_DONE-1:0] clr_v;
    logic [NUM_DONE-1:0] done_v;

    assign sel = sel_e'(sel_mode);
    assign run = run_e'(run_mode);

    always_comb begin
        clr_v          = '0;
        clr_v[IDX_F1]  = clr_f1;
        clr_v[IDX_F2]  = clr_f2;
        clr_v[IDX_FRM] = clr_frm;
    end

    vcap_seq_window #(.POS_W(POS_W)) win_i (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .field_id    (field_id),
        .h_pos       (h_pos),
        .v_pos       (v_pos),
        .stop_size   (stop_size),
        .sel         (sel),
        .capturing   (capturing),
        .hit         (hit)
    );

    vcap_seq_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (cap_en),
        .frame_start (frame_start),
        .field_start (field_start),
        .field_id    (field_id),
        .sel         (sel),
        .run         (run),
        .hit         (hit),
        .sel_flag    (sel_flag),
        .sel_clr     (sel_clr),
        .capturing   (capturing)
    );

    vcap_seq_flags flags_i (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .sel      (sel),
        .clr      (clr_v),
        .clr_cmp  (clr_cmp),
        .irq_en   (irq_en),
        .done     (done_v),
        .cmp_done (cmp_done),
        .irq      (irq),
        .sel_flag (sel_flag),
        .sel_clr  (sel_clr)
    );

    assign cap_active = capturing;
    assign f1_done    = done_v[IDX_F1];
    assign f2_done    = done_v[IDX_F2];
    assign frm_done   = done_v[IDX_FRM];
endmodule

// File: rtl/vcap_frame_seq_chk.sv
module vcap_frame_seq_chk #(
    parameter int unsigned POS_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               cap_en,
    input logic               frame_start,
    input logic               field_start,
    input logic [POS_W-1:0]   h_pos,
    input logic [POS_W-1:0]   v_pos,
    input logic [2*POS_W-1:0] stop_size,
    input logic [1:0]         run_mode,
    input logic               clr_f1,
    input logic               clr_frm,
    input logic               irq_en,
    input logic               cap_active,
    input logic               f1_done,
    input logic               f2_done,
    input logic               frm_done,
    input logic               cmp_done,
    input logic               irq
);
    a_r2_start_on_field: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_active) |-> $past(field_start));

    a_r3_flag_from_capture: assert property (@(posedge clk) disable iff (rst)
        ($rose(f1_done) || $rose(f2_done) || $rose(frm_done)) |-> $past(cap_active));

    a_r3_flag_at_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(f1_done) |-> $past((h_pos == stop_size[POS_W-1:0]) &&
                                 (v_pos == stop_size[2*POS_W-1:POS_W])));

    a_r4_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && cmp_done));

    a_r4_summary_set: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_done) |-> cmp_done);

    a_r7_single_halts: assert property (@(posedge clk) disable iff (rst)
        ($rose(frm_done) && $past(run_mode == 2'd2)) |-> !cap_active);

    a_r8_f1_sticky: assert property (@(posedge clk) disable iff (rst)
        (f1_done && !clr_f1) |=> f1_done);

    a_r8_frm_sticky: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !clr_frm) |=> frm_done);

    a_r9_disable_idle: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !cap_en) |=> !cap_active);
endmodule

bind vcap_frame_seq vcap_frame_seq_chk #(.POS_W(POS_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cap_en      (cap_en),
    .frame_start (frame_start),
    .field_start (field_start),
    .h_pos       (h_pos),
    .v_pos       (v_pos),
    .stop_size   (stop_size),
    .run_mode    (run_mode),
    .clr_f1      (clr_f1),
    .clr_frm     (clr_frm),
    .irq_en      (irq_en),
    .cap_active  (cap_active),
    .f1_done     (f1_done),
    .f2_done     (f2_done),
    .frm_done    (frm_done),
    .cmp_done    (cmp_done),
    .irq         (irq)
);

// File: tb/vcap_frame_seq_tb_top.sv
module vcap_frame_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POS_W = 12;
    localparam int PIX   = 8;
    localparam int LINES = 6;
    localparam int XS    = 7;
    localparam int YS    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap_en = 1'b0, frame_start = 1'b0, field_start = 1'b0, field_id = 1'b0;
    logic [POS_W-1:0] h_pos = '1, v_pos = '1;
    logic [2*POS_W-1:0] stop_size;
    logic [1:0] sel_mode = 2'd0, run_mode = 2'd0;
    logic clr_f1 = 0, clr_f2 = 0, clr_frm = 0, clr_cmp = 0, irq_en = 1'b1;
    logic cap_active, f1_done, f2_done, frm_done, cmp_done, irq;

    int checks = 0, errors = 0, rises = 0;
    logic prev_cap = 1'b0;
    logic clr_on_hit = 1'b0;

    // reference model state
    int   m_st = 0;
    logic m_fld = 0, m_f1 = 0, m_f2 = 0, m_frm = 0, m_cmp = 0;

    assign stop_size = {12'(YS), 12'(XS)};

    always #(CLK_PERIOD/2) clk = ~clk;

    vcap_frame_seq #(.POS_W(POS_W)) dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .frame_start(frame_start),
        .field_start(field_start), .field_id(field_id), .h_pos(h_pos), .v_pos(v_pos),
        .stop_size(stop_size), .sel_mode(sel_mode), .run_mode(run_mode),
        .clr_f1(clr_f1), .clr_f2(clr_f2), .clr_frm(clr_frm), .clr_cmp(clr_cmp),
        .irq_en(irq_en), .cap_active(cap_active), .f1_done(f1_done), .f2_done(f2_done),
        .frm_done(frm_done), .cmp_done(cmp_done), .irq(irq));

    always @(posedge clk) begin
        logic efld, hit, fsel, cflag, cclr, bok;
        int nxt;
        if (rst) begin
            m_st = 0; m_fld = 0; m_f1 = 0; m_f2 = 0; m_frm = 0; m_cmp = 0;
        end else begin
            efld  = field_start ? field_id : m_fld;
            fsel  = (sel_mode >= 2);
            hit   = (m_st == 2) && (h_pos == XS) && (v_pos == YS) && (!fsel || efld);
            cflag = (sel_mode == 0) ? m_f1 : (sel_mode == 1) ? m_f2 : m_frm;
            cclr  = (sel_mode == 0) ? clr_f1 : (sel_mode == 1) ? clr_f2 : clr_frm;
            bok   = field_start && ((sel_mode == 1) ? field_id : !field_id);
            nxt   = m_st;
            if (frame_start && !cap_en) nxt = 0;
            else if (m_st == 0) begin
                if (frame_start && cap_en) nxt = bok ? 2 : 1;
            end else if (m_st == 1) begin
                if (bok) nxt = 2;
            end else if (m_st == 2) begin
                if (hit) begin
                    if (run_mode == 0) nxt = 1;
                    else if (run_mode == 1) nxt = (cflag && !cclr) ? 3 : 1;
                    else nxt = 3;
                end
            end else begin
                if (!cflag) nxt = 0;
            end
            m_f1  = (m_f1 && !clr_f1) || (hit && sel_mode == 0);
            m_f2  = (m_f2 && !clr_f2) || (hit && sel_mode == 1);
            m_frm = (m_frm && !clr_frm) || (hit && fsel);
            m_cmp = (m_cmp && !clr_cmp) || hit;
            if (field_start) m_fld = field_id;
            m_st = nxt;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cap_active == (m_st == 2), "R2", "cap_active", cap_active, m_st == 2);
        chk(f1_done == m_f1, "R3", "f1_done", f1_done, m_f1);
        chk(f2_done == m_f2, "R3", "f2_done", f2_done, m_f2);
        chk(frm_done == m_frm, "R3", "frm_done", frm_done, m_frm);
        chk(cmp_done == m_cmp, "R4", "cmp_done", cmp_done, m_cmp);
        chk(irq == (m_cmp && irq_en), "R4", "irq", irq, m_cmp && irq_en);
        if (cap_active && !prev_cap) rises++;
        prev_cap = cap_active;
    endtask

    task automatic idle_cycle(input logic c1, input logic c2, input logic cf, input logic cc);
        @(negedge clk);
        compare_all();
        frame_start = 0; field_start = 0; h_pos = '1; v_pos = '1;
        clr_f1 = c1; clr_f2 = c2; clr_frm = cf; clr_cmp = cc;
    endtask

    task automatic run_frames(input int n);
        for (int f = 0; f < n; f++)
            for (int fl = 0; fl < 2; fl++)
                for (int v = 0; v < LINES; v++)
                    for (int h = 0; h < PIX; h++) begin
                        @(negedge clk);
                        compare_all();
                        field_id    = fl[0];
                        field_start = (h == 0) && (v == 0);
                        frame_start = (h == 0) && (v == 0) && (fl == 0);
                        h_pos = POS_W'(h); v_pos = POS_W'(v);
                        clr_f1 = clr_on_hit && (h == XS) && (v == YS) && (fl == 0);
                        clr_f2 = 0; clr_frm = 0; clr_cmp = 0;
                    end
        idle_cycle(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cap_en = 0; frame_start = 0; field_start = 0;
        clr_f1 = 0; clr_f2 = 0; clr_frm = 0; clr_cmp = 0; clr_on_hit = 0;
        h_pos = '1; v_pos = '1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state seen at the ports on the first cycle after release
        chk({cap_active, f1_done, f2_done, frm_done, cmp_done, irq} == 6'b0, "R1",
            "outputs after reset",
            int'({cap_active, f1_done, f2_done, frm_done, cmp_done, irq}), 0);
        prev_cap = cap_active;
        rises = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R5: continuous, field 1 selection, three frames -> three capture starts
        do_reset();
        sel_mode = 0; run_mode = 0; cap_en = 1;
        run_frames(3);
        chk(rises == 3, "R5", "capture starts, continuous", rises, 3);
        chk(f1_done == 1 && f2_done == 0, "R3", "f1 only set", f1_done, 1);

        // R8: clear coinciding with the set leaves the flag set; a lone clear clears
        do_reset();
        sel_mode = 0; run_mode = 0; cap_en = 1; clr_on_hit = 1;
        run_frames(1);
        chk(f1_done == 1, "R8", "set wins over clear", f1_done, 1);
        clr_on_hit = 0;
        idle_cycle(1, 0, 0, 1);
        idle_cycle(0, 0, 0, 0);
        chk(f1_done == 0 && cmp_done == 0, "R8", "clear alone", f1_done, 0);

        // R6: non-continuous, no acknowledge -> two captures then halt
        do_reset();
        sel_mode = 0; run_mode = 1; cap_en = 1; irq_en = 0;
        run_frames(3);
        chk(rises == 2, "R6", "captures before halt", rises, 2);
        chk(irq == 0 && cmp_done == 1, "R4", "irq masked", irq, 0);
        irq_en = 1;
        idle_cycle(1, 0, 0, 0);
        idle_cycle(0, 0, 0, 0);
        idle_cycle(0, 0, 0, 0);
        rises = 0;
        run_frames(1);
        chk(rises == 1, "R6", "resume after clear", rises, 1);

        // R7: single frame mode, frame selection
        do_reset();
        sel_mode = 2; run_mode = 2; cap_en = 1;
        run_frames(3);
        chk(rises == 1, "R7", "single capture", rises, 1);
        chk(frm_done == 1 && irq == 1, "R7", "frame flag and irq", frm_done, 1);
        idle_cycle(0, 0, 1, 0);
        idle_cycle(0, 0, 0, 0);
        idle_cycle(0, 0, 0, 0);
        rises = 0;
        run_frames(2);
        chk(rises == 1, "R7", "recapture after clear", rises, 1);

        // R2 / R9: field 2 selection, then disable; flag is kept
        do_reset();
        sel_mode = 1; run_mode = 0; cap_en = 1;
        run_frames(1);
        chk(rises == 1 && f2_done == 1, "R2", "field 2 captured", rises, 1);
        cap_en = 0;
        run_frames(2);
        chk(rises == 1, "R9", "no capture while disabled", rises, 1);
        chk(f2_done == 1 && cap_active == 0, "R9", "flag kept, idle", f2_done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule